// File: doc/BRIEF.md
# Flash Status Polling Engine

The block keeps asking an external serial flash device for its status and waits for a chosen bit pattern to show up. Each poll is a request to a serial command sequencer. The engine raises a request, waits for it to be accepted, and then waits for the status word to come back. Once the word returns, it keeps only the bytes of the configured status width. It applies a programmable mask and compares the result against a programmed target value.

A match sets a sticky flag. If the interrupt enable is set, the flag also drives an interrupt line. The status word of the most recent read is held on an output whether or not it matched.

Software sets the mask, the target, the status width, the idle interval between polls and the auto-stop choice. It then pulses start. With auto-stop set, polling ends on the first match. Without it, polling runs until software aborts. An abort takes effect at the next point where no response is outstanding.

Top module: `flash_status_poller`

## Requirements
- R1: After reset, busy_o, req_valid_o, match_flag_o and irq_o are 0 and last_status_o is 0.
- R2: A start_i pulse sampled while idle makes busy_o and req_valid_o high from the next cycle. A start_i pulse sampled while busy has no effect.
- R3: req_valid_o stays high until it is sampled together with req_ready_i. A response on rsp_valid_i counts only while a request is outstanding, meaning it has been accepted and no response has come back yet.
- R4: In the cycle after each counted response, last_status_o holds rsp_data_i with every byte at index above cfg_bytes_i forced to zero. Byte k is bits 8k+7 to 8k, and cfg_bytes_i = n selects n+1 bytes. This holds whether or not the response matched.
- R5: A counted response matches when ((data ^ cfg_match_i) & cfg_mask_i) is zero over the selected bytes. A match sets match_flag_o in the next cycle.
- R6: match_flag_o stays set until a cycle where match_clr_i is high and no match occurs. A clear and a match in the same cycle leave the flag set.
- R7: irq_o is high exactly when match_flag_o and cfg_irq_en_i are both high.
- R8: With cfg_auto_stop_i high, a match ends polling: busy_o is low from the next cycle and no further request is raised. With it low, polling continues after a match.
- R9: After a response that does not end polling, req_valid_o stays low for exactly cfg_interval_i cycles after the response cycle. With cfg_interval_i = 0, the next request starts in the cycle right after the response.
- R10: While busy, an abort_i pulse is remembered and ends polling at the next counted response, or at once if the engine is waiting out the interval. An abort_i pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mask_i | input | 8*MAX_BYTES | Compare mask |
| cfg_match_i | input | 8*MAX_BYTES | Target status value |
| cfg_bytes_i | input | BYTES_W | Status width in bytes, minus one |
| cfg_interval_i | input | INTERVAL_W | Idle cycles between a response and the next request |
| cfg_auto_stop_i | input | 1 | Stop polling on the first match |
| cfg_irq_en_i | input | 1 | Match interrupt enable |
| start_i | input | 1 | Start pulse |
| abort_i | input | 1 | Abort pulse |
| match_clr_i | input | 1 | Write-one-to-clear pulse for the match flag |
| req_valid_o | output | 1 | Read-status command request |
| req_ready_i | input | 1 | Sequencer accepts the request |
| rsp_valid_i | input | 1 | Status word returned |
| rsp_data_i | input | 8*MAX_BYTES | Returned status word |
| busy_o | output | 1 | Polling in progress |
| match_flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Match interrupt |
| last_status_o | output | 8*MAX_BYTES | Most recently read status, width-masked |

## Verification
busy_o and req_valid_o change one cycle after the rising edge that samples start_i, abort_i or req_ready_i. last_status_o and match_flag_o change one cycle after the edge that samples a counted response. irq_o follows the flag in the same cycle. A request that resumes after the interval appears cfg_interval_i cycles after the response cycle. A bench model advances on each rising edge from the same sampled inputs, and every output is compared with it at the falling edge. Each expected value is therefore checked in exactly the cycle it is due. Directed checks add literal expectations for the interval length, the stop points and the flag and interrupt outcomes.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } poll_state_e;
endpackage

// File: rtl/fsp_width_mask.sv
module fsp_width_mask #(
  parameter int MAX_BYTES = 4,
  parameter int BYTES_W   = 2,
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic [BYTES_W-1:0] bytes_i,
  output logic [DATA_W-1:0]  mask_o
);
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    assign mask_o[8*k +: 8] = ({1'b0, bytes_i} >= (BYTES_W+1)'(k)) ? 8'hff : 8'h00;
  end
endmodule

// File: rtl/fsp_compare.sv
module fsp_compare #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic [DATA_W-1:0] width_i,
  output logic [DATA_W-1:0] data_o,
  output logic              hit_o
);
  assign data_o = data_i & width_i;
  assign hit_o  = ~|((data_i ^ match_i) & mask_i & width_i);
endmodule

// File: rtl/fsp_gap_timer.sv
module fsp_gap_timer #(
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [INTERVAL_W-1:0] value_i,
  output logic                  expire_o
);
  logic [INTERVAL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= value_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == INTERVAL_W'(1));

  p_count_down_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic auto_stop_i,
  input  logic interval_zero_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  input  logic hit_i,
  input  logic expire_i,
  output logic busy_o,
  output logic req_valid_o,
  output logic rsp_fire_o
);
  poll_state_e state_q, state_d;
  logic        pend_q;
  logic        stop_req;

  assign stop_req   = abort_i | pend_q;
  assign rsp_fire_o = (state_q == ST_WAIT) && rsp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_REQ;
      ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) begin
        if (stop_req || (auto_stop_i && hit_i)) state_d = ST_IDLE;
        else if (interval_zero_i)               state_d = ST_REQ;
        else                                    state_d = ST_GAP;
      end
      ST_GAP: begin
        if (stop_req)      state_d = ST_IDLE;
        else if (expire_i) state_d = ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_IDLE)                   pend_q <= 1'b0;
      else if (state_q != ST_IDLE && abort_i)   pend_q <= 1'b1;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && req_valid_o));
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> req_valid_o);
  p_auto_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fire_o && hit_i && auto_stop_i) |=> !busy_o);
  p_gap_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && abort_i) |=> !busy_o);
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller #(
  parameter int MAX_BYTES  = 4,
  parameter int INTERVAL_W = 16,
  localparam int DATA_W    = 8 * MAX_BYTES,
  localparam int BYTES_W   = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DATA_W-1:0]     cfg_mask_i,
  input  logic [DATA_W-1:0]     cfg_match_i,
  input  logic [BYTES_W-1:0]    cfg_bytes_i,
  input  logic [INTERVAL_W-1:0] cfg_interval_i,
  input  logic                  cfg_auto_stop_i,
  input  logic                  cfg_irq_en_i,
  input  logic                  start_i,
  input  logic                  abort_i,
  input  logic                  match_clr_i,
  output logic                  req_valid_o,
  input  logic                  req_ready_i,
  input  logic                  rsp_valid_i,
  input  logic [DATA_W-1:0]     rsp_data_i,
  output logic                  busy_o,
  output logic                  match_flag_o,
  output logic                  irq_o,
  output logic [DATA_W-1:0]     last_status_o
);
  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] trimmed;
  logic              hit;
  logic              rsp_fire;
  logic              expire;
  logic              flag_q;
  logic [DATA_W-1:0] last_q;

  fsp_width_mask #(.MAX_BYTES(MAX_BYTES), .BYTES_W(BYTES_W)) i_width (
    .bytes_i (cfg_bytes_i),
    .mask_o  (width_mask)
  );

  fsp_compare #(.DATA_W(DATA_W)) i_cmp (
    .data_i  (rsp_data_i),
    .mask_i  (cfg_mask_i),
    .match_i (cfg_match_i),
    .width_i (width_mask),
    .data_o  (trimmed),
    .hit_o   (hit)
  );

  fsp_gap_timer #(.INTERVAL_W(INTERVAL_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rsp_fire),
    .value_i  (cfg_interval_i),
    .expire_o (expire)
  );

  fsp_ctrl i_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .abort_i         (abort_i),
    .auto_stop_i     (cfg_auto_stop_i),
    .interval_zero_i (cfg_interval_i == '0),
    .req_ready_i     (req_ready_i),
    .rsp_valid_i     (rsp_valid_i),
    .hit_i           (hit),
    .expire_i        (expire),
    .busy_o          (busy_o),
    .req_valid_o     (req_valid_o),
    .rsp_fire_o      (rsp_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      last_q <= '0;
    end else begin
      // set wins over clear
      flag_q <= (rsp_fire && hit) | (flag_q & ~match_clr_i);
      if (rsp_fire) last_q <= trimmed;
    end
  end

  assign match_flag_o  = flag_q;
  assign irq_o         = flag_q & cfg_irq_en_i;
  assign last_status_o = last_q;

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !match_clr_i) |=> match_flag_o);
  p_last_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_fire |=> $stable(last_status_o));
  p_match_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fire && hit) |=> match_flag_o);
endmodule

// File: tb/test_flash_status_poller.sv
module test_flash_status_poller;
  localparam int CLK_PERIOD = 10;
  localparam int MB = 4;
  localparam int W  = 32;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] cfg_mask_i = '0, cfg_match_i = '0;
  logic [1:0] cfg_bytes_i = '0;
  logic [IW-1:0] cfg_interval_i = '0;
  logic cfg_auto_stop_i = 0, cfg_irq_en_i = 0;
  logic start_i = 0, abort_i = 0, match_clr_i = 0;
  logic req_valid_o, req_ready_i = 1'b1, rsp_valid_i = 1'b0;
  logic [W-1:0] rsp_data_i = '0;
  logic busy_o, match_flag_o, irq_o;
  logic [W-1:0] last_status_o;

  flash_status_poller #(.MAX_BYTES(MB), .INTERVAL_W(IW)) i_flash_status_poller (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_mask_i(cfg_mask_i), .cfg_match_i(cfg_match_i),
    .cfg_bytes_i(cfg_bytes_i), .cfg_interval_i(cfg_interval_i),
    .cfg_auto_stop_i(cfg_auto_stop_i), .cfg_irq_en_i(cfg_irq_en_i),
    .start_i(start_i), .abort_i(abort_i), .match_clr_i(match_clr_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .busy_o(busy_o), .match_flag_o(match_flag_o), .irq_o(irq_o),
    .last_status_o(last_status_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // responder
  logic [W-1:0] seq [16];
  int idx = 0, lat_cnt = 0, rsp_lat = 1;
  bit ready_toggle = 0;
  logic acc = 1'b0;
  always @(posedge clk) acc <= req_valid_o && req_ready_i;
  always @(negedge clk) begin
    #1;
    rsp_valid_i = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        rsp_valid_i = 1'b1;
        rsp_data_i  = seq[idx % 16];
        idx++;
      end
    end
    if (acc) lat_cnt = rsp_lat;
    req_ready_i = ready_toggle ? !req_ready_i : 1'b1;
  end

  // reference model
  int m_st = 0, m_cnt = 0, nst;
  bit m_pend = 0, m_fire, m_hit, m_stop;
  logic m_flag = 1'b0;
  logic [W-1:0] m_last = '0;

  function automatic logic [W-1:0] wmask(input logic [1:0] b);
    case (b)
      2'd0: return 32'h0000_00ff;
      2'd1: return 32'h0000_ffff;
      2'd2: return 32'h00ff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_pend = 0; m_flag = 0; m_last = '0;
    end else begin
      m_fire = (m_st == 2) && rsp_valid_i;
      m_hit  = m_fire && (((rsp_data_i ^ cfg_match_i) & cfg_mask_i & wmask(cfg_bytes_i)) == 0);
      m_stop = abort_i || m_pend;
      nst = m_st;
      case (m_st)
        0: if (start_i) nst = 1;
        1: if (req_ready_i) nst = 2;
        2: if (m_fire) begin
             if (m_stop || (cfg_auto_stop_i && m_hit)) nst = 0;
             else if (cfg_interval_i == 0) nst = 1;
             else nst = 3;
           end
        default: if (m_stop) nst = 0; else if (m_cnt == 1) nst = 1;
      endcase
      if (m_fire) m_cnt = int'(cfg_interval_i);
      else if (m_cnt != 0) m_cnt--;
      if (nst == 0) m_pend = 0;
      else if (m_st != 0 && abort_i) m_pend = 1;
      m_flag = m_hit || (m_flag && !match_clr_i);
      if (m_fire) m_last = rsp_data_i & wmask(cfg_bytes_i);
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      check("R2 R8 R10 busy_o", W'(busy_o), W'(m_st != 0));
      check("R3 R9 req_valid_o", W'(req_valid_o), W'(m_st == 1));
      check("R5 R6 match_flag_o", W'(match_flag_o), W'(m_flag));
      check("R7 irq_o", W'(irq_o), W'(m_flag && cfg_irq_en_i));
      check("R4 last_status_o", last_status_o, m_last);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse_start(); step(1); start_i = 1; step(1); start_i = 0; endtask
  task automatic pulse_abort(); step(1); abort_i = 1; step(1); abort_i = 0; endtask
  task automatic wait_idle(); step(1); while (busy_o) step(1); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lows, start_idx;
    step(3);
    check("R1 busy_o in reset", W'(busy_o), 0);
    check("R1 match_flag_o in reset", W'(match_flag_o), 0);
    rst_ni = 1;
    step(2);
    check("R1 req_valid_o after reset", W'(req_valid_o), 0);
    check("R1 last_status_o after reset", last_status_o, 0);

    // A: 1 byte, bit0 clear wanted, auto stop, clear held high to meet the final match
    seq[0] = 32'h0000_0103; seq[1] = 32'h0000_0001; seq[2] = 32'h0000_0180;
    idx = 0; cfg_bytes_i = 0; cfg_mask_i = 32'h1; cfg_match_i = 32'h0;
    cfg_interval_i = 3; cfg_auto_stop_i = 1; cfg_irq_en_i = 1; match_clr_i = 1;
    pulse_start();
    wait_idle();
    check("R4 width trimmed last status", last_status_o, 32'h80);
    check("R6 match with clear keeps flag", W'(match_flag_o), 1);
    check("R8 auto stop after third read", W'(idx), 3);
    match_clr_i = 0;
    step(6);
    check("R8 no request after auto stop", W'(idx), 3);
    check("R7 irq_o with enable", W'(irq_o), 1);
    step(1); match_clr_i = 1; step(1); match_clr_i = 0; step(1);
    check("R6 clear pulse drops flag", W'(match_flag_o), 0);

    // C: 2 bytes, no auto stop, interval 0, toggling ready, latency 2
    for (int i = 0; i < 16; i++) seq[i] = 32'h0000_5555;
    seq[0] = 32'h00ab_1234; seq[1] = 32'h0;
    idx = 0; cfg_bytes_i = 1; cfg_mask_i = 32'hffff_ffff; cfg_match_i = 32'h0000_1234;
    cfg_interval_i = 0; cfg_auto_stop_i = 0; cfg_irq_en_i = 0;
    ready_toggle = 1; rsp_lat = 2;
    pulse_start();
    step(2); start_i = 1; step(1); start_i = 0;
    while (idx < 4) step(1);
    check("R8 polling continues without auto stop", W'(busy_o), 1);
    check("R6 flag sticky across non-matching reads", W'(match_flag_o), 1);
    check("R7 irq_o masked by enable", W'(irq_o), 0);
    pulse_abort();
    wait_idle();
    check("R10 abort ends polling", W'(busy_o), 0);
    start_idx = idx;
    step(8);
    check("R10 no request after abort", W'(idx), W'(start_idx));

    // D: interval length, then abort inside the interval
    cfg_interval_i = 4; ready_toggle = 0; rsp_lat = 1;
    step(2); match_clr_i = 1; step(1); match_clr_i = 0;
    pulse_start();
    while (!req_valid_o) step(1);
    while (req_valid_o) step(1);
    lows = 0;
    while (!req_valid_o) begin lows++; step(1); end
    check("R9 low cycles between requests", W'(lows), W'(2 + 4));
    start_idx = idx;
    while (idx == start_idx) step(1);
    step(1); abort_i = 1; step(1); abort_i = 0;
    check("R10 abort in interval stops at once", W'(busy_o), 0);

    // E: abort while idle is ignored; 4 bytes with partial mask
    seq[0] = 32'h12ff_34ff; idx = 0;
    cfg_bytes_i = 3; cfg_mask_i = 32'hff00_ff00; cfg_match_i = 32'h1200_3400;
    cfg_auto_stop_i = 1; cfg_interval_i = 2; cfg_irq_en_i = 1;
    pulse_abort();
    check("R10 abort while idle no effect", W'(busy_o), 0);
    pulse_start();
    check("R2 busy after start", W'(busy_o), 1);
    wait_idle();
    check("R5 masked 4-byte match stops", W'(idx), 1);
    check("R4 full width last status", last_status_o, 32'h12ff_34ff);
    check("R5 match flag set", W'(match_flag_o), 1);

    step(4);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule